// File: doc/BRIEF.md
# Push-Button System-Error Pulser

This block turns a mechanical push-button into a single, well-formed assertion on a shared, active-low, open-drain system-error line. Its only timing reference is the bus clock. The raw switch level is brought into the clock domain by a flop chain and then filtered by a stability counter. Only the accepted transition from released to pressed counts as an event.

Each event makes the block pull the line low for exactly one clock. It then lets go of the line and leaves it floating, so the pull-up restores it. It never drives the line high. After every pulse a re-arm window of at least two clocks keeps the line released, so other agents see it de-asserted on at least two successive rising edges. A press that arrives inside that window is either held back and fired as soon as the window closes, or dropped, as chosen by a parameter.

The outputs feed an external tri-state pad: an enable that is high only in the assertion cycle, and a data value that is always 0.

Top module: `serr_pulser`

## Requirements
- R1: The raw button passes through SYNC_STAGES flops (default 2) before any other logic. From a raw edge to the first cycle of the pulse takes SYNC_STAGES + DEBOUNCE_CYCLES + 1 clocks.
- R2: A new button level is accepted only after the synchronized input has differed from the accepted level on DEBOUNCE_CYCLES consecutive clock edges (default 65536). Any shorter excursion is discarded and restarts the count.
- R3: Only an accepted released-to-pressed transition (level 1 = pressed) creates an event. Holding the button creates no further events until it is released and pressed again.
- R4: `pad_oe` is high for exactly one clock per event and is never high on two consecutive clocks.
- R5: `pad_do` is 0 at all times, so the pad either drives low or floats.
- R6: Between two pulses `pad_oe` stays low for at least IDLE_CYCLES clocks. Values below 2 are raised to 2.
- R7: With HOLD_PENDING = 1, an event that arrives during a pulse or its re-arm window is remembered. It fires on the first clock after the window, so the two pulses start IDLE_CYCLES + 1 clocks apart.
- R8: With HOLD_PENDING = 0, an event that arrives during a pulse or its re-arm window is discarded, including one in the window's last cycle.
- R9: Synchronous active-high `rst` clears the synchronizer, the debouncer, the window and any held event. `pad_oe` is low during reset and on the clock after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the only timing reference |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Raw, asynchronous push-button level, 1 = pressed |
| pad_oe | output | 1 | Pad output enable, high only in the assertion cycle |
| pad_do | output | 1 | Pad data value, constantly 0 |

## Verification
The two functions that can fall in the same cycle are the arrival of a new debounced press and the close of the re-arm window after an earlier pulse. The bench provokes this by pressing, releasing and pressing again quickly enough that the second accepted press lands inside the window. It drives one instance in hold mode and one in drop mode from the same button. The hold instance must give exactly two pulses spaced IDLE_CYCLES + 1 clocks apart, and the drop instance exactly one. A reset applied while a press is being held back must discard it.

// File: rtl/serrp_pkg.sv
package serrp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRE  = 2'd1,
    ST_REARM = 2'd2
  } pstate_e;

  // counter width able to hold values 0 .. n-1
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // re-arm window never shorter than two released clocks
  function automatic int idle_floor(input int n);
    return (n < 2) ? 2 : n;
  endfunction

  // stability count never shorter than two samples
  function automatic int debounce_floor(input int n);
    return (n < 2) ? 2 : n;
  endfunction

endpackage

// File: rtl/serrp_sync.sv
module serrp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int NS = (STAGES < 2) ? 2 : STAGES;

  logic [NS-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[NS-2:0], din};
  end

  assign dout = chain[NS-1];
endmodule

// File: rtl/serrp_debounce.sv
module serrp_debounce #(
  parameter int CYCLES = 65536
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic press_evt
);
  localparam int N  = serrp_pkg::debounce_floor(CYCLES);
  localparam int CW = serrp_pkg::cnt_width(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      level     <= 1'b0;
      cnt       <= '0;
      press_evt <= 1'b0;
    end else begin
      press_evt <= 1'b0;
      if (din == level) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        level     <= din;
        cnt       <= '0;
        press_evt <= din;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serrp_pulse_ctrl.sv
module serrp_pulse_ctrl
  import serrp_pkg::*;
#(
  parameter int IDLE_CYCLES  = 2,
  parameter bit HOLD_PENDING = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic press_evt,
  output logic fire,
  output logic rearm_last,
  output logic pending
);
  localparam int IW = idle_floor(IDLE_CYCLES);
  localparam int CW = cnt_width(IW);
  localparam logic [CW-1:0] LOAD = CW'(IW - 1);

  pstate_e       state, state_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          pending_d;
  logic          busy;

  assign busy       = (state != ST_IDLE);
  assign rearm_last = (state == ST_REARM) && (cnt == '0);

  always_comb begin
    state_d   = state;
    cnt_d     = cnt;
    pending_d = pending;
    if (HOLD_PENDING && busy && press_evt) pending_d = 1'b1;
    unique case (state)
      ST_IDLE: if (press_evt) state_d = ST_FIRE;
      ST_FIRE: begin
        state_d = ST_REARM;
        cnt_d   = LOAD;
      end
      ST_REARM: begin
        if (cnt == '0) begin
          if (HOLD_PENDING && (pending || press_evt)) state_d = ST_FIRE;
          else                                        state_d = ST_IDLE;
        end else begin
          cnt_d = cnt - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (state_d == ST_FIRE) pending_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      state   <= state_d;
      cnt     <= cnt_d;
      pending <= pending_d;
    end
  end

  assign fire = (state == ST_FIRE);
endmodule

// File: rtl/serr_pulser.sv
module serr_pulser #(
  parameter int SYNC_STAGES     = 2,
  parameter int DEBOUNCE_CYCLES = 65536,
  parameter int IDLE_CYCLES     = 2,
  parameter bit HOLD_PENDING    = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic pad_oe,
  output logic pad_do
);
  localparam int IDLE_EFF = serrp_pkg::idle_floor(IDLE_CYCLES);

  logic btn_sync;
  logic db_level;
  logic press_evt;
  logic rearm_last;
  logic pending;
  logic fire;

  serrp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (btn_raw),
    .dout (btn_sync)
  );

  serrp_debounce #(.CYCLES(DEBOUNCE_CYCLES)) u_debounce (
    .clk       (clk),
    .rst       (rst),
    .din       (btn_sync),
    .level     (db_level),
    .press_evt (press_evt)
  );

  serrp_pulse_ctrl #(
    .IDLE_CYCLES  (IDLE_EFF),
    .HOLD_PENDING (HOLD_PENDING)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .press_evt  (press_evt),
    .fire       (fire),
    .rearm_last (rearm_last),
    .pending    (pending)
  );

  assign pad_oe = fire;
  assign pad_do = 1'b0;
endmodule

// File: rtl/serrp_checker.sv
module serrp_checker #(
  parameter int IDLE_CYCLES  = 2,
  parameter bit HOLD_PENDING = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic pad_oe,
  input logic pad_do,
  input logic press_evt,
  input logic db_level,
  input logic rearm_last,
  input logic pending
);
  localparam int SW = $clog2(IDLE_CYCLES + 1);
  localparam logic [SW-1:0] SAT = SW'(IDLE_CYCLES);

  logic [SW-1:0] since;

  always_ff @(posedge clk) begin
    if (rst)             since <= SAT;
    else if (pad_oe)     since <= '0;
    else if (since < SAT) since <= since + 1'b1;
  end

  p_single_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    pad_oe |=> !pad_oe);

  p_never_drive_high_r5: assert property (@(posedge clk) disable iff (rst)
    pad_do == 1'b0);

  p_idle_gap_r6: assert property (@(posedge clk) disable iff (rst)
    pad_oe |-> (since >= SAT));

  p_press_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
    press_evt |-> (db_level && !$past(db_level)));

  p_pending_fires_r7: assert property (@(posedge clk) disable iff (rst)
    (HOLD_PENDING && rearm_last && pending) |=> pad_oe);

  p_drop_in_window_r8: assert property (@(posedge clk) disable iff (rst)
    (!HOLD_PENDING && rearm_last) |=> !pad_oe);

  p_released_after_reset_r9: assert property (@(posedge clk)
    rst |=> !pad_oe);
endmodule

bind serr_pulser serrp_checker #(
  .IDLE_CYCLES  (IDLE_EFF),
  .HOLD_PENDING (HOLD_PENDING)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pad_oe     (pad_oe),
  .pad_do     (pad_do),
  .press_evt  (press_evt),
  .db_level   (db_level),
  .rearm_last (rearm_last),
  .pending    (pending)
);

// File: tb/serr_pulser_bench.sv
module serr_pulser_bench;
  localparam int S    = 2;
  localparam int N    = 4;
  localparam int IDLE = 40;

  // {on1, gap, on2, tail, expected pulses hold, expected pulses drop}
  localparam int NV = 7;
  localparam int VEC [NV][6] = '{
    '{20,  0,  0, 100, 1, 1},
    '{3,   0,  0, 100, 0, 0},
    '{4,   0,  0, 100, 1, 1},
    '{300, 0,  0, 100, 1, 1},
    '{10, 10, 10, 100, 2, 1},
    '{10,  2, 10, 100, 1, 1},
    '{2,   1,  2, 100, 0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic oe_h, do_h, oe_d, do_d;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  serr_pulser #(.SYNC_STAGES(S), .DEBOUNCE_CYCLES(N), .IDLE_CYCLES(IDLE),
                .HOLD_PENDING(1'b1)) u_serr_pulser (
    .clk(clk), .rst(rst), .btn_raw(btn), .pad_oe(oe_h), .pad_do(do_h));

  serr_pulser #(.SYNC_STAGES(S), .DEBOUNCE_CYCLES(N), .IDLE_CYCLES(IDLE),
                .HOLD_PENDING(1'b0)) u_serr_pulser_drop (
    .clk(clk), .rst(rst), .btn_raw(btn), .pad_oe(oe_d), .pad_do(do_d));

  function automatic int exp_latency(input int stages, input int dbn);
    return stages + dbn + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // negedge monitor
  int cyc = 0;
  int np_h = 0, np_d = 0;
  int last_h = -1000, last_d = -1000;
  int space_h = 0;
  int consec_viol = 0, space_viol = 0, do_viol = 0;
  bit prev_h = 1'b0, prev_d = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (do_h !== 1'b0 || do_d !== 1'b0) do_viol++;
    if (oe_h === 1'b1) begin
      if (prev_h) consec_viol++;
      else begin
        if (cyc - last_h < IDLE + 1) space_viol++;
        space_h = cyc - last_h;
        last_h  = cyc;
        np_h++;
      end
    end
    if (oe_d === 1'b1) begin
      if (prev_d) consec_viol++;
      else begin
        if (cyc - last_d < IDLE + 1) space_viol++;
        last_d = cyc;
        np_d++;
      end
    end
    prev_h = (oe_h === 1'b1);
    prev_d = (oe_d === 1'b1);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    int bh, bd;
    idle(3);
    check(oe_h == 1'b0 && oe_d == 1'b0, "R9 oe during reset", oe_h, 0);
    check(do_h == 1'b0, "R5 do during reset", do_h, 0);
    rst = 1'b0;
    idle(1);
    check(oe_h == 1'b0, "R9 oe after reset", oe_h, 0);
    idle(10);

    // vector table
    for (int v = 0; v < NV; v++) begin
      bh = np_h;
      bd = np_d;
      btn = 1'b1; idle(VEC[v][0]);
      btn = 1'b0; idle(VEC[v][1]);
      if (VEC[v][2] > 0) begin
        btn = 1'b1; idle(VEC[v][2]);
        btn = 1'b0;
      end
      idle(VEC[v][3]);
      check(np_h - bh == VEC[v][4], $sformatf("R2/R3/R7 vector %0d hold pulses", v),
            np_h - bh, VEC[v][4]);
      check(np_d - bd == VEC[v][5], $sformatf("R2/R3/R8 vector %0d drop pulses", v),
            np_d - bd, VEC[v][5]);
      if (v == 4)
        check(space_h == IDLE + 1, "R7 held press spacing", space_h, IDLE + 1);
    end

    // R1 exact latency
    btn = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (oe_h !== 1'b1 && lat < 60);
    check(lat == exp_latency(S, N), "R1 latency", lat, exp_latency(S, N));
    idle(1);
    check(oe_h == 1'b0, "R4 released after one cycle", oe_h, 0);
    btn = 1'b0;
    idle(100);

    // R9 reset clears a held press
    bh = np_h;
    btn = 1'b1; idle(10);
    btn = 1'b0; idle(10);
    btn = 1'b1; idle(10);
    btn = 1'b0; idle(10);
    rst = 1'b1; idle(2);
    check(oe_h == 1'b0, "R9 oe in mid-window reset", oe_h, 0);
    rst = 1'b0; idle(1);
    check(oe_h == 1'b0, "R9 oe right after reset", oe_h, 0);
    idle(100);
    check(np_h - bh == 1, "R9 held press discarded by reset", np_h - bh, 1);

    // global monitors
    check(consec_viol == 0, "R4 no two-cycle assertion", consec_viol, 0);
    check(space_viol == 0, "R6 minimum idle gap", space_viol, 0);
    check(do_viol == 0, "R5 data stays low", do_viol, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule